// File: doc/BRIEF.md
# Timing Reference Selection Controller

This block chooses which recovered line clock a system synchronizer locks to. Every candidate reference has its own qualification monitor, and a reference counts as healthy only while none of the monitor's impairment checks has fired. The checks are: a run of zeros with no one bit for a set time, a sustained error rate in back-to-back bit windows, a qualifying phase hit, and an external excessive-jitter flag.

The controller keeps the active reference until that reference itself becomes unhealthy. It then moves to the healthy reference that ranks highest in a configured priority list. When no reference is healthy, it raises a free-run request so that the synchronizer holds its frequency. Every change of selection, including entering and leaving free-run, starts a holdoff period. During the holdoff the selection is frozen, which prevents chatter. A reference that recovers during the holdoff is only considered once the holdoff has ended.

All timing is counted in ticks from a prescaler on the local clock. Every duration is a parameter, so a simulation can use short values.

Top module: `ref_select_ctrl`

## Requirements
- R1: After any selection change (new reference, entry to free-run or exit from free-run), `sel_idx` and `free_run` hold their values for HOLDOFF_TICKS ticks.
- R2: A reference becomes unqualified after LOS_TICKS ticks with no one bit sampled (a one bit is `bit_val` high while `bit_en` is high). Its next one bit requalifies it at once.
- R3: Each BER_WIN_BITS enabled bits form one window. A window is bad if it receives BER_THRESH or more `err_stb` pulses. A reference is unqualified after BER_BAD_WINS bad windows in a row, and the first good window clears this.
- R4: A `hit_stb` pulse with `hit_slope_ok` high disqualifies its reference for HIT_HOLD_TICKS ticks. A pulse with `hit_slope_ok` low has no effect.
- R5: A reference is unqualified on the cycle after its `jit_flag` is high, and stays unqualified while the flag stays high.
- R6: A switch happens only when the active reference is unqualified. The controller never switches because of a priority change or because a better reference came back. The target of a switch is the first qualified reference in `prio_order`, where slot k is bits [k*IDXW +: IDXW] and slot 0 ranks highest.
- R7: When the active reference fails and no reference is qualified, `free_run` rises and `sel_idx` keeps its last value. Once the holdoff has ended and a reference is qualified, `free_run` falls and the best qualified reference is selected.
- R8: After reset, `free_run` is 0, all `ref_qual` bits are 1, and `sel_idx` is the reference in priority slot 0.
- R9: A reference that requalifies while the holdoff is running is evaluated when the holdoff expires, and it is chosen then if it ranks best.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | NREF | Per-reference recovered bit strobe |
| bit_val | input | NREF | Per-reference recovered bit value |
| err_stb | input | NREF | Per-reference bit-error pulse |
| hit_stb | input | NREF | Per-reference phase-hit pulse (amplitude over limit) |
| hit_slope_ok | input | NREF | Phase-hit slope at or below the limit |
| jit_flag | input | NREF | Excessive input jitter, level |
| prio_order | input | NREF*IDXW | Reference index per priority slot, slot 0 highest |
| sel_idx | output | IDXW | Index of the selected reference |
| free_run | output | 1 | Request for the synchronizer to free-run |
| ref_qual | output | NREF | Per-reference qualification status |

## Verification
On every cycle the assertions check four things. The selection is frozen while the holdoff counter is running. A healthy active reference is never replaced. Free-run is entered only after every reference was unqualified. A jitter flag or a valid phase hit removes the reference's qualification on the next cycle. The bench scenarios are needed for the rest: the duration qualifiers (the zero-run length, consecutive bad error windows, the error-count threshold at exactly one below and at the limit), the choice among several references by priority, deferred re-evaluation of a reference that recovers mid-holdoff, and the return from free-run.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  typedef enum logic [1:0] {
    SEL_INIT = 2'd0,
    SEL_LOCK = 2'd1,
    SEL_FREE = 2'd2
  } sel_state_e;

  // Width of a counter that must reach 'limit'
  function automatic int cnt_w(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // A window is bad once its error count reaches the threshold
  function automatic logic window_bad(input logic [31:0] errs, input logic [31:0] thresh);
    return errs >= thresh;
  endfunction

endpackage

// File: rtl/rsc_tick_gen.sv
module rsc_tick_gen
  import rsc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PW = cnt_w(TICK_DIV);
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end

  assign tick = (pre_q == LAST);
endmodule

// File: rtl/rsc_ref_monitor.sv
module rsc_ref_monitor
  import rsc_pkg::*;
#(
  parameter int unsigned LOS_TICKS      = 100,
  parameter int unsigned BER_WIN_BITS   = 1544,
  parameter int unsigned BER_THRESH     = 2,
  parameter int unsigned BER_BAD_WINS   = 2500,
  parameter int unsigned HIT_HOLD_TICKS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bit_en,
  input  logic bit_val,
  input  logic err_stb,
  input  logic hit_stb,
  input  logic hit_slope_ok,
  input  logic jit_flag,
  output logic qual
);
  localparam int LW = cnt_w(LOS_TICKS);
  localparam int BW = cnt_w(BER_WIN_BITS);
  localparam int EW = cnt_w(BER_THRESH);
  localparam int RW = cnt_w(BER_BAD_WINS);
  localparam int HW = cnt_w(HIT_HOLD_TICKS);

  localparam logic [LW-1:0] LOS_LIM  = LW'(LOS_TICKS);
  localparam logic [BW-1:0] WIN_LAST = BW'(BER_WIN_BITS - 1);
  localparam logic [EW-1:0] ERR_LIM  = EW'(BER_THRESH);
  localparam logic [RW-1:0] RUN_LIM  = RW'(BER_BAD_WINS);
  localparam logic [HW-1:0] HIT_LIM  = HW'(HIT_HOLD_TICKS);

  // ---------------- zero-run (loss of signal) timer, R2
  logic [LW-1:0] zero_ticks_q;
  logic          one_seen;
  logic          los;

  assign one_seen = bit_en & bit_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               zero_ticks_q <= '0;
    else if (one_seen)                        zero_ticks_q <= '0;
    else if (tick && zero_ticks_q != LOS_LIM) zero_ticks_q <= zero_ticks_q + 1'b1;
  end

  assign los = (zero_ticks_q == LOS_LIM);

  // ---------------- windowed error-rate judge, R3
  logic [BW-1:0] win_bits_q;
  logic [EW-1:0] win_errs_q;
  logic [EW:0]   errs_total;
  logic [RW-1:0] bad_run_q;
  logic          win_end;
  logic          win_is_bad;
  logic          ber_bad;

  assign win_end    = bit_en && (win_bits_q == WIN_LAST);
  assign errs_total = {1'b0, win_errs_q} + {{EW{1'b0}}, err_stb};
  assign win_is_bad = window_bad(32'(errs_total), 32'(BER_THRESH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_bits_q <= '0;
      win_errs_q <= '0;
      bad_run_q  <= '0;
    end else if (win_end) begin
      win_bits_q <= '0;
      win_errs_q <= '0;
      if (!win_is_bad)             bad_run_q <= '0;
      else if (bad_run_q != RUN_LIM) bad_run_q <= bad_run_q + 1'b1;
    end else begin
      if (bit_en)                          win_bits_q <= win_bits_q + 1'b1;
      if (err_stb && win_errs_q != ERR_LIM) win_errs_q <= win_errs_q + 1'b1;
    end
  end

  assign ber_bad = (bad_run_q == RUN_LIM);

  // ---------------- phase-hit hold, R4
  logic [HW-1:0] hit_left_q;
  logic          hit_valid;
  logic          hit_bad;

  assign hit_valid = hit_stb & hit_slope_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        hit_left_q <= '0;
    else if (hit_valid)                hit_left_q <= HIT_LIM;
    else if (tick && hit_left_q != '0) hit_left_q <= hit_left_q - 1'b1;
  end

  assign hit_bad = (hit_left_q != '0);

  // ---------------- jitter flag, R5
  logic jit_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) jit_q <= 1'b0;
    else        jit_q <= jit_flag;
  end

  assign qual = !(los | ber_bad | hit_bad | jit_q);
endmodule

// File: rtl/rsc_select_fsm.sv
module rsc_select_fsm
  import rsc_pkg::*;
#(
  parameter int unsigned NREF          = 4,
  parameter int unsigned IDXW          = 2,
  parameter int unsigned HOLDOFF_TICKS = 10000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [NREF-1:0]      ref_qual,
  input  logic [NREF*IDXW-1:0] prio_order,
  output logic [IDXW-1:0]      sel_idx,
  output logic                 free_run,
  output logic                 sw_evt,
  output logic                 hold_busy,
  output logic                 in_init
);
  localparam int HOW = cnt_w(HOLDOFF_TICKS);
  localparam logic [HOW-1:0] HOLD_LIM = HOW'(HOLDOFF_TICKS);

  // First qualified reference in priority order; MSB flags "found"
  function automatic logic [IDXW:0] pick_best(input logic [NREF-1:0] q,
                                              input logic [NREF*IDXW-1:0] pr);
    logic [IDXW:0]   res;
    logic [IDXW-1:0] id;
    res = '0;
    for (int k = NREF - 1; k >= 0; k--) begin
      id = pr[k*IDXW +: IDXW];
      if (32'(id) < NREF && q[id]) res = {1'b1, id};
    end
    return res;
  endfunction

  sel_state_e      state_q, state_d;
  logic [IDXW-1:0] sel_q, sel_d;
  logic [HOW-1:0]  hold_q;
  logic [IDXW:0]   best;
  logic            any_ok;
  logic            act_ok;

  assign best      = pick_best(ref_qual, prio_order);
  assign any_ok    = best[IDXW];
  assign act_ok    = ref_qual[sel_q];
  assign hold_busy = (hold_q != '0);

  always_comb begin
    state_d = state_q;
    sel_d   = sel_q;
    sw_evt  = 1'b0;
    case (state_q)
      SEL_INIT: begin
        if (any_ok) begin
          state_d = SEL_LOCK;
          sel_d   = best[IDXW-1:0];
        end else begin
          state_d = SEL_FREE;
        end
      end
      SEL_LOCK: begin
        if (!hold_busy && !act_ok) begin
          sw_evt = 1'b1;
          if (any_ok) sel_d   = best[IDXW-1:0];
          else        state_d = SEL_FREE;
        end
      end
      SEL_FREE: begin
        if (!hold_busy && any_ok) begin
          sw_evt  = 1'b1;
          state_d = SEL_LOCK;
          sel_d   = best[IDXW-1:0];
        end
      end
      default: state_d = SEL_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEL_INIT;
      sel_q   <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      if (sw_evt)                hold_q <= HOLD_LIM;
      else if (tick && hold_busy) hold_q <= hold_q - 1'b1;
    end
  end

  assign sel_idx  = sel_q;
  assign free_run = (state_q == SEL_FREE);
  assign in_init  = (state_q == SEL_INIT);
endmodule

// File: rtl/ref_select_ctrl.sv
module ref_select_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned NREF           = 4,
  parameter int unsigned TICK_DIV       = 125000,
  parameter int unsigned LOS_TICKS      = 100,
  parameter int unsigned BER_WIN_BITS   = 1544,
  parameter int unsigned BER_THRESH     = 2,
  parameter int unsigned BER_BAD_WINS   = 2500,
  parameter int unsigned HIT_HOLD_TICKS = 1000,
  parameter int unsigned HOLDOFF_TICKS  = 10000,
  localparam int unsigned IDXW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREF-1:0]      bit_en,
  input  logic [NREF-1:0]      bit_val,
  input  logic [NREF-1:0]      err_stb,
  input  logic [NREF-1:0]      hit_stb,
  input  logic [NREF-1:0]      hit_slope_ok,
  input  logic [NREF-1:0]      jit_flag,
  input  logic [NREF*IDXW-1:0] prio_order,
  output logic [IDXW-1:0]      sel_idx,
  output logic                 free_run,
  output logic [NREF-1:0]      ref_qual
);
  logic tick;
  logic sw_evt;
  logic hold_busy;
  logic in_init;

  rsc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst_n(rst_n),
    .tick(tick)
  );

  for (genvar g = 0; g < NREF; g++) begin : g_mon
    rsc_ref_monitor #(
      .LOS_TICKS     (LOS_TICKS),
      .BER_WIN_BITS  (BER_WIN_BITS),
      .BER_THRESH    (BER_THRESH),
      .BER_BAD_WINS  (BER_BAD_WINS),
      .HIT_HOLD_TICKS(HIT_HOLD_TICKS)
    ) u_mon (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .bit_en      (bit_en[g]),
      .bit_val     (bit_val[g]),
      .err_stb     (err_stb[g]),
      .hit_stb     (hit_stb[g]),
      .hit_slope_ok(hit_slope_ok[g]),
      .jit_flag    (jit_flag[g]),
      .qual        (ref_qual[g])
    );
  end

  rsc_select_fsm #(
    .NREF         (NREF),
    .IDXW         (IDXW),
    .HOLDOFF_TICKS(HOLDOFF_TICKS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ref_qual  (ref_qual),
    .prio_order(prio_order),
    .sel_idx   (sel_idx),
    .free_run  (free_run),
    .sw_evt    (sw_evt),
    .hold_busy (hold_busy),
    .in_init   (in_init)
  );
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
  parameter int unsigned NREF = 4,
  localparam int unsigned IDXW = (NREF > 1) ? $clog2(NREF) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREF-1:0] hit_stb,
  input logic [NREF-1:0] hit_slope_ok,
  input logic [NREF-1:0] jit_flag,
  input logic [IDXW-1:0] sel_idx,
  input logic            free_run,
  input logic [NREF-1:0] ref_qual,
  input logic            sw_evt,
  input logic            hold_busy,
  input logic            in_init
);
  // R1
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |=> ($stable(sel_idx) && $stable(free_run)));

  // R6
  keep_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_init && !free_run && ref_qual[sel_idx]) |=> ($stable(sel_idx) && !free_run));

  // R6
  switch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_evt |-> (free_run || !ref_qual[sel_idx]));

  // R7
  free_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(free_run) |-> ($past(ref_qual) == '0));

  for (genvar g = 0; g < NREF; g++) begin : g_ref
    // R5
    jit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      jit_flag[g] |=> !ref_qual[g]);

    // R4
    hit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_stb[g] && hit_slope_ok[g]) |=> !ref_qual[g]);
  end
endmodule

bind ref_select_ctrl rsc_checker #(.NREF(NREF)) u_rsc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hit_stb     (hit_stb),
  .hit_slope_ok(hit_slope_ok),
  .jit_flag    (jit_flag),
  .sel_idx     (sel_idx),
  .free_run    (free_run),
  .ref_qual    (ref_qual),
  .sw_evt      (sw_evt),
  .hold_busy   (hold_busy),
  .in_init     (in_init)
);

// File: tb/ref_select_ctrl_bench.sv
`timescale 1ns/1ps
module ref_select_ctrl_bench;
  localparam int NR = 3;
  localparam int IW = 2;
  // slot0 in bits [1:0]
  localparam logic [5:0] P012 = {2'd2, 2'd1, 2'd0};
  localparam logic [5:0] P102 = {2'd2, 2'd0, 2'd1};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] alive = '1;
  logic [NR-1:0] err_mask = '0;
  logic [NR-1:0] err_pulse = '0;
  logic [NR-1:0] hit = '0;
  logic [NR-1:0] slope = '0;
  logic [NR-1:0] jit = '0;
  logic [5:0]    prio = P012;
  logic [IW-1:0] sel_idx;
  logic          free_run;
  logic [NR-1:0] ref_qual;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ref_select_ctrl #(
    .NREF(NR), .TICK_DIV(4), .LOS_TICKS(5), .BER_WIN_BITS(8), .BER_THRESH(2),
    .BER_BAD_WINS(3), .HIT_HOLD_TICKS(6), .HOLDOFF_TICKS(10)
  ) u_ref_select_ctrl (
    .clk(clk), .rst_n(rst_n),
    .bit_en({NR{1'b1}}), .bit_val(alive), .err_stb(err_mask | err_pulse),
    .hit_stb(hit), .hit_slope_ok(slope), .jit_flag(jit), .prio_order(prio),
    .sel_idx(sel_idx), .free_run(free_run), .ref_qual(ref_qual)
  );

  typedef struct packed {
    logic [2:0] alv;
    logic [2:0] err;
    logic [2:0] jt;
    logic [5:0] pr;
    logic [1:0] sel;
    logic       fr;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{3'b111, 3'b000, 3'b000, P012, 2'd0, 1'b0},
    '{3'b110, 3'b000, 3'b000, P012, 2'd1, 1'b0},
    '{3'b111, 3'b000, 3'b000, P012, 2'd1, 1'b0},
    '{3'b111, 3'b010, 3'b000, P012, 2'd0, 1'b0},
    '{3'b111, 3'b010, 3'b001, P012, 2'd2, 1'b0},
    '{3'b111, 3'b000, 3'b000, P102, 2'd2, 1'b0},
    '{3'b011, 3'b000, 3'b000, P102, 2'd1, 1'b0},
    '{3'b000, 3'b000, 3'b000, P102, 2'd1, 1'b1},
    '{3'b100, 3'b000, 3'b000, P102, 2'd2, 1'b0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R6 baseline";
      1: return "R2 zero run";
      2: return "R6 no revert";
      3: return "R3 error rate";
      4: return "R5 jitter";
      5: return "R6 priority change";
      6: return "R2 priority pick";
      7: return "R7 all failed";
      default: return "R7 leave free-run";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    alive = '1; err_mask = '0; err_pulse = '0; hit = '0; slope = '0; jit = '0; prio = P012;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      failures++;
      $display("FAIL watchdog all-R actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    do_reset();
    chk("R8 sel after reset", sel_idx, 0);
    chk("R8 free_run after reset", free_run, 0);
    chk("R8 qual after reset", ref_qual, 3'b111);

    // table walk
    for (int i = 0; i < 9; i++) begin
      alive = VECS[i].alv; err_mask = VECS[i].err; jit = VECS[i].jt; prio = VECS[i].pr;
      wait_n(90);
      chk(tag_of(i), sel_idx, VECS[i].sel);
      chk(tag_of(i), free_run, VECS[i].fr);
    end

    // R1 / R9 holdoff and deferred re-evaluation
    do_reset();
    jit = 3'b001;
    wait_n(5);
    chk("R5 jitter switch", sel_idx, 1);
    jit = 3'b011;
    wait_n(20);
    chk("R1 frozen in holdoff", sel_idx, 1);
    jit = 3'b010;
    wait_n(45);
    chk("R9 requalified ref taken after holdoff", sel_idx, 0);

    // R4 phase hits
    do_reset();
    hit = 3'b010; slope = 3'b000;
    wait_n(1);
    hit = '0;
    wait_n(2);
    chk("R4 steep hit ignored", ref_qual[1], 1);
    hit = 3'b001; slope = 3'b001;
    wait_n(1);
    hit = '0; slope = '0;
    wait_n(4);
    chk("R4 hit disqualifies", ref_qual[0], 0);
    chk("R4 hit switch", sel_idx, 1);
    wait_n(40);
    chk("R4 hit hold expired", ref_qual[0], 1);
    chk("R6 no return after hit", sel_idx, 1);

    // R2 zero-run boundary
    do_reset();
    alive = 3'b110;
    wait_n(12);
    chk("R2 short zero run", ref_qual[0], 1);
    alive = 3'b111;
    wait_n(2);
    alive = 3'b110;
    wait_n(40);
    chk("R2 long zero run", ref_qual[0], 0);
    alive = 3'b111;
    wait_n(2);
    chk("R2 one bit requalifies", ref_qual[0], 1);

    // R3 error threshold boundary
    do_reset();
    for (int c = 0; c < 80; c++) begin
      err_pulse[1] = (c % 8 == 0);
      @(negedge clk);
    end
    chk("R3 one below threshold", ref_qual[1], 1);
    for (int c = 0; c < 48; c++) begin
      err_pulse[1] = (c % 8 < 2);
      @(negedge clk);
    end
    err_pulse = '0;
    chk("R3 at threshold", ref_qual[1], 0);
    chk("R6 inactive fault no switch", sel_idx, 0);
    wait_n(20);
    chk("R3 good window clears", ref_qual[1], 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule